// File: doc/BRIEF.md
# Vector Byte Gather Unit

This unit performs a byte-granular table lookup for a SIMD datapath. A 64-bit index word carries eight byte-wide indices. Each index addresses one byte of a virtual table built from one to four consecutive 128-bit vector registers, beginning at a chosen register number. The unit fetches each needed byte through a synchronous read port. That port returns one 64-bit half of a 32-entry, 128-bit-wide register file per access. The unit assembles the eight bytes into a 64-bit result.

The caller supplies an initial result word together with the index word. Any lane whose index falls outside the table keeps its byte from that initial word. An all-zero initial word gives the zeroing form of the operation. Passing the current destination contents gives the merging form. A table that runs past the last register continues at register zero.

The controller is a three-state machine. ST_IDLE waits for `start`. The transition IDLE→ISSUE captures the operands and preloads the result with the initial word. ST_ISSUE spends one cycle per lane, lanes 0 to 7 in order, and issues a read only for a valid lane. The transition ISSUE→FINISH follows the lane-7 cycle. ST_FINISH merges the last returned byte. The transition FINISH→IDLE raises `done` for one cycle.

Top module: `vec_byte_gather`

## Requirements
- R1: Result byte k (bits 8k+7:8k) is produced from the index in `idx_word` bits 8k+7:8k, for k = 0 to 7.
- R2: An index is in range only when its unsigned value is below 16 × (effective table register count).
- R3: A lane whose index is out of range returns the matching byte of `init_word` unchanged. This covers both an all-zero word (zeroing) and arbitrary data (merging).
- R4: For an in-range index i, the element number is e = (2 × `base_reg` + i[7:3]) mod 64. The register read is e[5:1], and `rf_rd_half` = e[0] selects the high 64-bit half (1) or the low half (0). As a result, the table wraps from register 31 to register 0.
- R5: Within the returned half, the byte taken is bits 8·i[2:0]+7 : 8·i[2:0] of `rf_rd_data`.
- R6: A `tbl_count` of 1 to 4 gives that many table registers. Any other value (0, 5, 6, 7) is treated as 4.
- R7: Exactly one read (`rf_rd_en` high for one cycle) is issued for each in-range lane, and none for an out-of-range lane. Reads occur only while `busy` is high. Read data is taken in the cycle after the read.
- R8: `done` is a one-cycle pulse, high in the ninth cycle after the edge that accepted `start`. At that point `result` holds the finished word, and it stays unchanged until the next accepted start.
- R9: `busy` is high for exactly nine cycles per operation. A `start` that arrives while `busy` is high is ignored.
- R10: While reset is asserted and right after it, `busy`, `done` and `rf_rd_en` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup; sampled only while idle |
| idx_word | input | 64 | Eight byte indices, lane k in bits 8k+7:8k |
| init_word | input | 64 | Initial result bytes kept by out-of-range lanes |
| base_reg | input | 5 | First table register number |
| tbl_count | input | 3 | Table size in registers (1 to 4, others mean 4) |
| rf_rd_en | output | 1 | Register file read strobe |
| rf_rd_addr | output | 5 | Register number to read |
| rf_rd_half | output | 1 | 1 selects bits 127:64, 0 selects bits 63:0 |
| rf_rd_data | input | 64 | Selected half, valid one cycle after the read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Assembled result word |

## Verification
The bench targets an index just below and just at the range limit for each table size. A design with an off-by-one limit would either fetch a byte it should leave alone or keep an initial byte it should replace. A table based at register 31 checks the wrap to register 0: a design that failed to wrap would read register 32, truncated, or the wrong half. The bench also drives out-of-range table counts, operations with every lane out of range (which must issue no reads), a start pulse during an operation (which must not restart it or alter its result), and a start on the same cycle as `done`.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
    parameter int LANES     = 8;
    parameter int IDX_W     = 8;
    parameter int HALF_W    = 64;
    parameter int VEC_W     = 128;
    parameter int NREGS     = 32;
    parameter int MAX_TBL   = 4;
    parameter int CNT_W     = 3;

    localparam int REG_AW   = $clog2(NREGS);
    localparam int ELEM_W   = REG_AW + 1;
    localparam int BOFF_W   = $clog2(HALF_W / 8);
    localparam int LANE_W   = $clog2(LANES);
    localparam int LIMIT_W  = IDX_W + 1;
    localparam int VEC_BYTES = VEC_W / 8;
    localparam int WORD_W   = LANES * IDX_W;
    localparam int BUSY_CYC = LANES + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } gather_state_t;

    typedef struct packed {
        logic              valid;
        logic [REG_AW-1:0] rnum;
        logic              half;
        logic [BOFF_W-1:0] boff;
    } lane_sel_t;
endpackage

// File: rtl/vbg_limit_calc.sv
module vbg_limit_calc
    import vbg_pkg::*;
(
    input  logic [CNT_W-1:0]   tbl_count,
    output logic [LIMIT_W-1:0] limit
);
    logic [CNT_W-1:0] eff_count;

    always_comb begin
        if (tbl_count >= CNT_W'(1) && tbl_count <= CNT_W'(MAX_TBL))
            eff_count = tbl_count;
        else
            eff_count = CNT_W'(MAX_TBL);
        limit = LIMIT_W'(eff_count) * LIMIT_W'(VEC_BYTES);
    end
endmodule

// File: rtl/vbg_lane_decode.sv
module vbg_lane_decode
    import vbg_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    input  logic [REG_AW-1:0]  base,
    input  logic [LIMIT_W-1:0] limit,
    output lane_sel_t          sel
);
    logic [ELEM_W-1:0] elem;

    always_comb begin
        elem      = {base, 1'b0} + ELEM_W'(idx[IDX_W-1:BOFF_W]);
        sel.valid = LIMIT_W'(idx) < limit;
        sel.rnum  = elem[ELEM_W-1:1];
        sel.half  = elem[0];
        sel.boff  = idx[BOFF_W-1:0];
    end
endmodule

// File: rtl/vbg_byte_merge.sv
module vbg_byte_merge
    import vbg_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [HALF_W-1:0] src,
    input  logic [LANE_W-1:0] lane,
    input  logic [BOFF_W-1:0] boff,
    output logic [WORD_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        nxt[lane*IDX_W +: IDX_W] = src[boff*8 +: 8];
    end
endmodule

// File: rtl/vec_byte_gather.sv
module vec_byte_gather
    import vbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       idx_word,
    input  logic [63:0]       init_word,
    input  logic [4:0]        base_reg,
    input  logic [2:0]        tbl_count,
    output logic              rf_rd_en,
    output logic [4:0]        rf_rd_addr,
    output logic              rf_rd_half,
    input  logic [63:0]       rf_rd_data,
    output logic              busy,
    output logic              done,
    output logic [63:0]       result
);
    gather_state_t state, state_nx;

    logic [WORD_W-1:0]  idx_q;
    logic [REG_AW-1:0]  base_q;
    logic [LIMIT_W-1:0] limit_in, limit_q;
    logic [LANE_W-1:0]  lane_q;
    logic               pend_v;
    logic [LANE_W-1:0]  pend_lane;
    logic [BOFF_W-1:0]  pend_boff;
    logic [WORD_W-1:0]  result_q, merged;
    logic               done_q;
    lane_sel_t          sel_all [LANES];
    lane_sel_t          cur_sel;
    logic               accept;

    vbg_limit_calc u_limit (
        .tbl_count (tbl_count),
        .limit     (limit_in)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        vbg_lane_decode u_dec (
            .idx   (idx_q[k*IDX_W +: IDX_W]),
            .base  (base_q),
            .limit (limit_q),
            .sel   (sel_all[k])
        );
    end

    assign cur_sel = sel_all[lane_q];
    assign accept  = (state == ST_IDLE) && start;

    vbg_byte_merge u_merge (
        .cur  (result_q),
        .src  (rf_rd_data),
        .lane (pend_lane),
        .boff (pend_boff),
        .nxt  (merged)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ISSUE;
            ST_ISSUE:  if (lane_q == LANE_W'(LANES - 1)) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rf_rd_en   = 1'b0;
        rf_rd_addr = cur_sel.rnum;
        rf_rd_half = cur_sel.half;
        unique case (state)
            ST_IDLE:   rf_rd_en = 1'b0;
            ST_ISSUE:  rf_rd_en = cur_sel.valid;
            ST_FINISH: rf_rd_en = 1'b0;
            default:   rf_rd_en = 1'b0;
        endcase
        busy   = (state != ST_IDLE);
        done   = done_q;
        result = result_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            base_q    <= '0;
            limit_q   <= '0;
            lane_q    <= '0;
            pend_v    <= 1'b0;
            pend_lane <= '0;
            pend_boff <= '0;
            result_q  <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (state == ST_FINISH);
            if (accept) begin
                idx_q    <= idx_word;
                base_q   <= base_reg;
                limit_q  <= limit_in;
                result_q <= init_word;
                lane_q   <= '0;
                pend_v   <= 1'b0;
            end else if (state == ST_ISSUE) begin
                pend_v    <= cur_sel.valid;
                pend_lane <= lane_q;
                pend_boff <= cur_sel.boff;
                lane_q    <= lane_q + LANE_W'(1);
                if (pend_v) result_q <= merged;
            end else if (state == ST_FINISH) begin
                pend_v <= 1'b0;
                if (pend_v) result_q <= merged;
            end
        end
    end
endmodule

// File: rtl/vbg_checker.sv
module vbg_checker
    import vbg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        rf_rd_en,
    input logic        busy,
    input logic        done,
    input logic [63:0] result
);
    logic [LANE_W:0] rd_cnt;
    logic [LANE_W+1:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt   <= '0;
            busy_len <= '0;
        end else begin
            if (start && !busy) rd_cnt <= '0;
            else if (rf_rd_en)  rd_cnt <= rd_cnt + 1'b1;
            if (busy) busy_len <= busy_len + 1'b1;
            else      busy_len <= '0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R8
    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));                                              // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));                             // R8
    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> busy);                                                 // R7
    AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= (LANE_W+1)'(LANES));                                      // R7
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == (LANE_W+2)'(BUSY_CYC)));               // R9
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));                                      // R9
endmodule

bind vec_byte_gather vbg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rf_rd_en (rf_rd_en),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/sim_vec_byte_gather.sv
module sim_vec_byte_gather;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] idx_word = '0;
    logic [63:0] init_word = '0;
    logic [4:0]  base_reg = '0;
    logic [2:0]  tbl_count = 3'd1;
    logic        rf_rd_en;
    logic [4:0]  rf_rd_addr;
    logic        rf_rd_half;
    logic [63:0] rf_rd_data = '0;
    logic        busy, done;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    logic [127:0] rf_mem [32];
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_byte_gather u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .idx_word(idx_word),
        .init_word(init_word), .base_reg(base_reg), .tbl_count(tbl_count),
        .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_half(rf_rd_half),
        .rf_rd_data(rf_rd_data), .busy(busy), .done(done), .result(result)
    );

    initial begin
        for (int r = 0; r < 32; r++)
            for (int b = 0; b < 16; b++)
                rf_mem[r][b*8 +: 8] = 8'((r * 37 + b * 11 + 3) % 256);
    end

    always @(posedge clk)
        if (rf_rd_en) rf_rd_data <= rf_rd_half ? rf_mem[rf_rd_addr][127:64]
                                               : rf_mem[rf_rd_addr][63:0];

    function automatic int eff_regs(input logic [2:0] c);
        return (c >= 1 && c <= 4) ? int'(c) : 4;
    endfunction

    function automatic logic [63:0] ref_calc(input logic [63:0] iw, input logic [63:0] init,
                                             input logic [4:0] base, input logic [2:0] c);
        logic [63:0] res = init;
        for (int k = 0; k < 8; k++) begin
            int i = int'(iw[k*8 +: 8]);
            if (i < 16 * eff_regs(c)) begin
                int e = (2 * int'(base) + i / 8) % 64;
                int r = e / 2;
                int h = e % 2;
                res[k*8 +: 8] = rf_mem[r][h*64 + (i % 8) * 8 +: 8];
            end
        end
        return res;
    endfunction

    function automatic int ref_reads(input logic [63:0] iw, input logic [2:0] c);
        int n = 0;
        for (int k = 0; k < 8; k++)
            if (int'(iw[k*8 +: 8]) < 16 * eff_regs(c)) n++;
        return n;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic        m_busy = 1'b0, m_done = 1'b0;
    int          m_timer = 0, m_reads = 0, rd_seen = 0;
    logic [63:0] m_exp = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_timer = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                if (rf_rd_en) rd_seen++;
                m_timer++;
                if (m_timer == 9) begin m_busy = 1'b0; m_done = 1'b1; end
            end else if (start) begin
                m_busy  = 1'b1;
                m_timer = 0;
                rd_seen = 0;
                m_exp   = ref_calc(idx_word, init_word, base_reg, tbl_count);
                m_reads = ref_reads(idx_word, tbl_count);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 busy", 64'(busy), 64'(m_busy));
            chk("R8 done", 64'(done), 64'(m_done));
            if (rf_rd_en && !m_busy) chk("R7 read outside op", 64'(rf_rd_en), 64'd0);
            if (m_done) begin
                chk({cur_tag, " result"}, result, m_exp);
                chk("R7 read count", 64'(rd_seen), 64'(m_reads));
            end
        end
    end

    task automatic launch(input logic [63:0] iw, input logic [63:0] init,
                          input logic [4:0] base, input logic [2:0] c);
        idx_word = iw; init_word = init; base_reg = base; tbl_count = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input string tag, input logic [63:0] iw, input logic [63:0] init,
                          input logic [4:0] base, input logic [2:0] c);
        @(negedge clk);
        cur_tag = tag;
        launch(iw, init, base, c);
        repeat (11) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset busy", 64'(busy), 64'd0);
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R10 reset rd_en", 64'(rf_rd_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 post-reset result", result, 64'd0);
        chk("R10 post-reset busy", 64'(busy), 64'd0);

        // zeroing form, one register, limit edge 0x0F/0x10
        run_op("R1 R2 R3 R5", 64'h2005_0807_FF10_0F00, 64'd0, 5'd3, 3'd1);
        // merging form, two registers, limit edge 0x1F/0x20
        run_op("R2 R3 R4", 64'h1F20_1811_0A21_0203, 64'hDEAD_BEEF_CAFE_F00D, 5'd10, 3'd2);
        // wrap from register 31 to register 0
        run_op("R4 wrap", 64'h3F30_2820_1810_0800, 64'h0123_4567_89AB_CDEF, 5'd31, 3'd4);
        // three registers, limit edge 0x2F/0x30
        run_op("R2 three", 64'h2F30_0001_2E31_1C1D, 64'hAAAA_AAAA_AAAA_AAAA, 5'd30, 3'd3);
        // counts outside 1..4 act as 4
        run_op("R6 count0", 64'h3F40_3031_4041_3E00, 64'h5555_5555_5555_5555, 5'd7, 3'd0);
        run_op("R6 count7", 64'h3F40_3031_4041_3E00, 64'h5555_5555_5555_5555, 5'd7, 3'd7);
        run_op("R6 count5", 64'h3F40_2F00_1001_3A3B, 64'h1111_2222_3333_4444, 5'd16, 3'd5);
        // every lane out of range: no reads, init returned
        run_op("R3 R7 none", 64'hFF80_4140_7F90_C1E2, 64'h8765_4321_0FED_CBA9, 5'd0, 3'd4);

        // start while busy is ignored
        @(negedge clk);
        cur_tag = "R9 ignore";
        launch(64'h0706_0504_0302_0100, 64'd0, 5'd2, 3'd1);
        repeat (3) @(negedge clk);
        idx_word = 64'h3333_3333_3333_3333; init_word = '1; base_reg = 5'd20; tbl_count = 3'd4;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);

        // start in the done cycle is accepted
        @(negedge clk);
        cur_tag = "R8 back";
        launch(64'h0F0E_0D0C_0B0A_0908, 64'd0, 5'd5, 3'd1);
        while (!m_done) @(negedge clk);
        chk("R8 done seen", 64'(done), 64'd1);
        cur_tag = "R8 back2";
        launch(64'h1716_1514_1312_1110, 64'hFFFF_0000_FFFF_0000, 5'd9, 3'd2);
        repeat (11) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule